// File: doc/BRIEF.md
# Peripheral Write Access Firewall

This block stands between a system interconnect and a row of peripheral register windows. It takes one transaction at a time over a valid/ready request channel. It works out which window the address falls in and which requester issued the access, then judges the access against that window's configuration. An access that passes is forwarded to the peripheral side. An access that fails never reaches the peripheral side: the requester gets an error response, and a one-cycle violation strobe reports the offending address, the requester identity and the reason.

Three rules apply to every access that lands in a window:
- **Secure rule.** A window flagged secure accepts only secure-tagged accesses.
- **Lock rule.** While the global lock is raised, a window whose lock enable is set refuses writes to its control register.
- **Block mask.** A per-window 32-bit protection word can bar individual requesters from writing. Bits [2:0] refuse writes from core requesters 0..2. Bits [18:16] refuse writes from system requesters 0..2.

The configuration is presented as static inputs by a separate bank. The number of windows, the window size, the base address and the control register offset are parameters.

The controller is a four-state machine:
- **IDLE.** Ready is high. A valid request moves it to CHECK.
- **CHECK.** The captured request is judged and the verdict is registered. A failing verdict moves it to RESP. A passing verdict moves it to FWD.
- **FWD.** It holds the downstream access until the peripheral side is ready, then moves to RESP.
- **RESP.** It holds the response until the requester takes it, then returns to IDLE.

Top module: `periph_fw`

## Requirements
- R1: After reset, `up_ready` is 1 and `up_rvalid`, `dn_valid` and `viol_valid` are 0.
- R2: A write by core requester i (class bit 0, index 0..2) to a window whose protection word has bit i set is rejected with cause code 1 (mask). The same write from a core requester whose bit is clear is forwarded.
- R3: A write by system requester i (class bit 1, index 0..2) is rejected with cause 1 when bit 16+i of the window's protection word is set. A core requester with the same index is not affected by that bit.
- R4: Each window uses only its own protection word. A requester blocked on one window can write to another window whose word leaves it clear.
- R5: Reads are never judged against the protection word.
- R6: When a window's secure flag is set, any non-secure read or write to it is rejected with cause code 2 (secure). Secure accesses proceed to the remaining rules.
- R7: While `cfg_glock` is 1 and the window's lock enable is 1, every write to the window's control register (offset `CTRL_OFF`) is rejected with cause code 3 (lock), whatever the requester. Reads, other offsets, windows without lock enable, and the state with `cfg_glock` at 0 are not affected by this rule.
- R8: An address outside every window is forwarded without any check.
- R9: When more than one rule fails, the reported cause is chosen in the order secure, then lock, then mask.
- R10: Each rejection raises `viol_valid` for exactly one cycle, in the first cycle of the error response. During that cycle `viol_addr`, `viol_id` ({class, index}) and `viol_cause` describe the rejected access.
- R11: Timing and handshake:
  - An accepted request drops `up_ready` until its response is taken.
  - A rejection shows `up_rvalid` in the second cycle after acceptance.
  - A forwarded access shows `dn_valid` in that same cycle and holds it stable until `dn_ready`.
  - The response then holds until `up_rready`.
- R12: A forwarded access returns the peripheral-side read data on `up_rdata` with `up_err` at 0. A rejected access returns `up_err` at 1 and `up_rdata` at 0.
- R13: Requester index 3, in either class, has no protection bit and is never blocked by the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Request valid |
| up_ready | output | 1 | Request accepted when high with up_valid |
| up_addr | input | ADDR_W | Request address |
| up_write | input | 1 | 1 for write, 0 for read |
| up_wdata | input | DATA_W | Write data |
| up_req_sys | input | 1 | Requester class: 0 core, 1 system |
| up_req_idx | input | 2 | Requester index within its class |
| up_secure | input | 1 | Access carries the secure attribute |
| up_rvalid | output | 1 | Response valid |
| up_rready | input | 1 | Requester takes the response |
| up_err | output | 1 | Response is an error |
| up_rdata | output | DATA_W | Response read data |
| dn_valid | output | 1 | Forwarded access valid |
| dn_ready | input | 1 | Peripheral side completes the access |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_secure | output | 1 | Forwarded secure attribute |
| dn_rdata | input | DATA_W | Peripheral read data, valid with dn_ready |
| cfg_prot | input | NPER*32 | Protection words, window k at bits [32k+31:32k] |
| cfg_slv_secure | input | NPER | Secure-only flag per window |
| cfg_lock_en | input | NPER | Lock enable per window |
| cfg_glock | input | 1 | Global lock |
| viol_valid | output | 1 | One-cycle rejection strobe |
| viol_addr | output | ADDR_W | Rejected address |
| viol_id | output | 3 | Rejected requester {class, index} |
| viol_cause | output | 2 | 1 mask, 2 secure, 3 lock |

## Verification
The bench targets several corner cases:
- **Class confusion.** The same index is used in both requester classes against one mask bit. A design that ignored the class bit would block the wrong requester.
- **Reads.** Reads are sent to masked windows. A design that applied the mask to reads would reject them.
- **Overlapping failures.** Accesses are built so that secure and lock, or lock and mask, fail together. A wrong priority shows up as a wrong cause code.
- **Lock scope.** The lock is exercised at the control offset, at a neighbouring offset, on a window without lock enable, and with the global lock lowered. A lock decoded too widely or too narrowly rejects the wrong one of these.
- **Window edges.** Addresses just below the first window and just past the last are sent, along with index-3 requesters against an all-ones word. These expose decode overrun and a mask lookup past bit 2.
- **Stalls.** Stalls on both the peripheral side and the response side check that nothing advances early.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    typedef enum logic [1:0] {
        CZ_NONE   = 2'd0,
        CZ_MASK   = 2'd1,
        CZ_SECURE = 2'd2,
        CZ_LOCK   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FWD,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic       sys;
        logic [1:0] idx;
    } rqid_t;

    localparam int WORD_W    = 32;
    localparam int CORE_LSB  = 0;
    localparam int SYS_LSB   = 16;
    localparam int PER_CLASS = 3;

endpackage

// File: rtl/pfw_decode.sv
module pfw_decode #(
    parameter int              ADDR_W   = 32,
    parameter int              NPER     = 8,
    parameter int              WIN_BITS = 12,
    parameter logic [ADDR_W-1:0] BASE   = 32'h4000_0000,
    parameter logic [WIN_BITS-1:0] CTRL_OFF = '0,
    localparam int             IDX_W    = (NPER > 1) ? $clog2(NPER) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              is_ctrl
);
    localparam int PG_W = ADDR_W - WIN_BITS;
    localparam logic [PG_W-1:0] BASE_PAGE = BASE[ADDR_W-1:WIN_BITS];

    logic [PG_W-1:0] page;
    logic [NPER-1:0] win_hit;

    assign page = addr[ADDR_W-1:WIN_BITS];

    for (genvar k = 0; k < NPER; k++) begin : g_win
        assign win_hit[k] = (page == BASE_PAGE + PG_W'(k));
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < NPER; k++) begin
            if (win_hit[k]) idx = idx | IDX_W'(k);
        end
    end

    assign hit     = |win_hit;
    assign is_ctrl = (addr[WIN_BITS-1:0] == CTRL_OFF);

endmodule

// File: rtl/pfw_rules.sv
module pfw_rules
    import pfw_pkg::*;
#(
    parameter int NPER  = 8,
    localparam int IDX_W = (NPER > 1) ? $clog2(NPER) : 1
) (
    input  logic                  hit,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  is_ctrl,
    input  logic                  write,
    input  rqid_t                 rqid,
    input  logic                  secure,
    input  logic [NPER*WORD_W-1:0] cfg_prot,
    input  logic [NPER-1:0]       cfg_slv_secure,
    input  logic [NPER-1:0]       cfg_lock_en,
    input  logic                  cfg_glock,
    output cause_e                cause
);
    logic [2*PER_CLASS-1:0] blk_bits [NPER];
    logic [NPER*(WORD_W-2*PER_CLASS)-1:0] unused_prot;

    for (genvar k = 0; k < NPER; k++) begin : g_word
        assign blk_bits[k] = {cfg_prot[k*WORD_W+SYS_LSB +: PER_CLASS],
                              cfg_prot[k*WORD_W+CORE_LSB +: PER_CLASS]};
        assign unused_prot[k*(WORD_W-2*PER_CLASS) +: (WORD_W-2*PER_CLASS)] =
            {cfg_prot[k*WORD_W+SYS_LSB+PER_CLASS +: WORD_W-SYS_LSB-PER_CLASS],
             cfg_prot[k*WORD_W+PER_CLASS +: SYS_LSB-PER_CLASS]};
    end

    logic [2*PER_CLASS-1:0] sel_bits;
    logic mask_bit;
    logic sec_fail, lock_fail, mask_fail;

    assign sel_bits = blk_bits[idx];

    always_comb begin
        mask_bit = 1'b0;
        for (int c = 0; c < PER_CLASS; c++) begin
            if (rqid.idx == 2'(c))
                mask_bit = rqid.sys ? sel_bits[PER_CLASS + c] : sel_bits[c];
        end
    end

    assign sec_fail  = hit && cfg_slv_secure[idx] && !secure;
    assign lock_fail = hit && write && is_ctrl && cfg_glock && cfg_lock_en[idx];
    assign mask_fail = hit && write && mask_bit;

    always_comb begin
        if (sec_fail)       cause = CZ_SECURE;
        else if (lock_fail) cause = CZ_LOCK;
        else if (mask_fail) cause = CZ_MASK;
        else                cause = CZ_NONE;
    end

endmodule

// File: rtl/pfw_ctrl.sv
module pfw_ctrl
    import pfw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   up_valid,
    input  logic   up_rready,
    input  logic   dn_ready,
    input  cause_e cause_i,
    output logic   up_ready,
    output logic   dn_valid,
    output logic   up_rvalid,
    output logic   err_o,
    output logic   accept,
    output logic   judging,
    output logic   fwd_done,
    output logic   viol_o,
    output cause_e cause_o
);
    state_e state, nxt;
    logic   err_q, viol_q;
    cause_e cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (up_valid)  nxt = ST_CHECK;
            ST_CHECK: nxt = (cause_i != CZ_NONE) ? ST_RESP : ST_FWD;
            ST_FWD:   if (dn_ready)  nxt = ST_RESP;
            ST_RESP:  if (up_rready) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            viol_q  <= 1'b0;
            cause_q <= CZ_NONE;
        end else begin
            viol_q <= (state == ST_CHECK) && (cause_i != CZ_NONE);
            if (state == ST_CHECK) begin
                err_q   <= (cause_i != CZ_NONE);
                cause_q <= cause_i;
            end
        end
    end

    always_comb begin
        up_ready  = (state == ST_IDLE);
        dn_valid  = (state == ST_FWD);
        up_rvalid = (state == ST_RESP);
        accept    = (state == ST_IDLE) && up_valid;
        judging   = (state == ST_CHECK);
        fwd_done  = (state == ST_FWD) && dn_ready;
        err_o     = (state == ST_RESP) && err_q;
        viol_o    = viol_q;
        cause_o   = cause_q;
    end

endmodule

// File: rtl/periph_fw.sv
module periph_fw
    import pfw_pkg::*;
#(
    parameter int                  ADDR_W   = 32,
    parameter int                  DATA_W   = 32,
    parameter int                  NPER     = 8,
    parameter int                  WIN_BITS = 12,
    parameter logic [ADDR_W-1:0]   BASE     = 32'h4000_0000,
    parameter logic [WIN_BITS-1:0] CTRL_OFF = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   up_valid,
    output logic                   up_ready,
    input  logic [ADDR_W-1:0]      up_addr,
    input  logic                   up_write,
    input  logic [DATA_W-1:0]      up_wdata,
    input  logic                   up_req_sys,
    input  logic [1:0]             up_req_idx,
    input  logic                   up_secure,
    output logic                   up_rvalid,
    input  logic                   up_rready,
    output logic                   up_err,
    output logic [DATA_W-1:0]      up_rdata,
    output logic                   dn_valid,
    input  logic                   dn_ready,
    output logic [ADDR_W-1:0]      dn_addr,
    output logic                   dn_write,
    output logic [DATA_W-1:0]      dn_wdata,
    output logic                   dn_secure,
    input  logic [DATA_W-1:0]      dn_rdata,
    input  logic [NPER*32-1:0]     cfg_prot,
    input  logic [NPER-1:0]        cfg_slv_secure,
    input  logic [NPER-1:0]        cfg_lock_en,
    input  logic                   cfg_glock,
    output logic                   viol_valid,
    output logic [ADDR_W-1:0]      viol_addr,
    output logic [2:0]             viol_id,
    output logic [1:0]             viol_cause
);
    localparam int IDX_W = (NPER > 1) ? $clog2(NPER) : 1;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              write_q, secure_q;
    rqid_t             rqid_q;

    logic              accept, judging, fwd_done, err_w, viol_w;
    logic              hit, is_ctrl;
    logic [IDX_W-1:0]  win_idx;
    cause_e            cause_w, cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            secure_q <= 1'b0;
            rqid_q   <= '0;
        end else if (accept) begin
            addr_q   <= up_addr;
            wdata_q  <= up_wdata;
            write_q  <= up_write;
            secure_q <= up_secure;
            rqid_q   <= '{sys: up_req_sys, idx: up_req_idx};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (judging)  rdata_q <= '0;
        else if (fwd_done) rdata_q <= dn_rdata;
    end

    pfw_decode #(
        .ADDR_W(ADDR_W), .NPER(NPER), .WIN_BITS(WIN_BITS),
        .BASE(BASE), .CTRL_OFF(CTRL_OFF)
    ) u_dec (
        .addr(addr_q), .hit(hit), .idx(win_idx), .is_ctrl(is_ctrl)
    );

    pfw_rules #(.NPER(NPER)) u_rules (
        .hit(hit), .idx(win_idx), .is_ctrl(is_ctrl), .write(write_q),
        .rqid(rqid_q), .secure(secure_q), .cfg_prot(cfg_prot),
        .cfg_slv_secure(cfg_slv_secure), .cfg_lock_en(cfg_lock_en),
        .cfg_glock(cfg_glock), .cause(cause_w)
    );

    pfw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_rready(up_rready),
        .dn_ready(dn_ready), .cause_i(cause_w), .up_ready(up_ready),
        .dn_valid(dn_valid), .up_rvalid(up_rvalid), .err_o(err_w),
        .accept(accept), .judging(judging), .fwd_done(fwd_done),
        .viol_o(viol_w), .cause_o(cause_q)
    );

    assign up_err     = err_w;
    assign up_rdata   = rdata_q;
    assign dn_addr    = addr_q;
    assign dn_write   = write_q;
    assign dn_wdata   = wdata_q;
    assign dn_secure  = secure_q;
    assign viol_valid = viol_w;
    assign viol_addr  = addr_q;
    assign viol_id    = rqid_q;
    assign viol_cause = cause_q;

endmodule

// File: rtl/pfw_chk.sv
module pfw_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic              up_rvalid,
    input logic              up_rready,
    input logic              up_err,
    input logic [DATA_W-1:0] up_rdata,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              viol_valid,
    input logic [1:0]        viol_cause
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |=> !viol_valid);

    a_r10_with_error: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (up_rvalid && up_err));

    a_r9_cause_known: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_cause != 2'd0));

    a_r11_accept_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> (!up_ready && !up_rvalid && !dn_valid));

    a_r11_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr)));

    a_r11_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rvalid && !up_rready) |=> (up_rvalid && $stable(up_err) && $stable(up_rdata)));

    a_r12_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rvalid && up_err) |-> (up_rdata == '0));

endmodule

bind periph_fw pfw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_rvalid(up_rvalid), .up_rready(up_rready), .up_err(up_err),
    .up_rdata(up_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .viol_valid(viol_valid), .viol_cause(viol_cause)
);

// File: tb/sim_periph_fw.sv
`timescale 1ns/1ps
module sim_periph_fw;
    localparam int NPER = 8;
    localparam int NV   = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        up_valid = 0, up_write = 0, up_req_sys = 0, up_secure = 0;
    logic [31:0] up_addr = 0, up_wdata = 0;
    logic [1:0]  up_req_idx = 0;
    logic        up_rready = 1, dn_ready = 1;
    logic        up_ready, up_rvalid, up_err, dn_valid, dn_write, dn_secure;
    logic [31:0] up_rdata, dn_addr, dn_wdata, dn_rdata, viol_addr;
    logic [NPER*32-1:0] cfg_prot;
    logic [NPER-1:0] cfg_slv_secure, cfg_lock_en;
    logic        cfg_glock;
    logic        viol_valid;
    logic [2:0]  viol_id;
    logic [1:0]  viol_cause;

    assign dn_rdata = dn_addr ^ 32'h5A5A_0000;

    periph_fw u0 (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // fields: addr, write, sys, idx, secure, exp_err, exp_cause
    localparam logic [39:0] VEC [NV] = '{
        {32'h4000_0000,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0}, // R4 open window
        {32'h4000_1010,1'b1,1'b0,2'd1,1'b0,1'b1,2'd1}, // R2 core1 blocked
        {32'h4000_1010,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0}, // R2 core0 free
        {32'h4000_1010,1'b1,1'b1,2'd1,1'b0,1'b0,2'd0}, // R3 sys1 not hit by core bit
        {32'h4000_2020,1'b1,1'b1,2'd0,1'b0,1'b1,2'd1}, // R3 sys0 blocked
        {32'h4000_2020,1'b1,1'b1,2'd2,1'b0,1'b1,2'd1}, // R3 sys2 blocked
        {32'h4000_2020,1'b1,1'b1,2'd1,1'b0,1'b0,2'd0}, // R3 sys1 free
        {32'h4000_2020,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0}, // R4 core0 free here
        {32'h4000_1010,1'b0,1'b0,2'd1,1'b0,1'b0,2'd0}, // R5 read ignores mask
        {32'h4000_3000,1'b0,1'b0,2'd0,1'b0,1'b1,2'd2}, // R6 nonsecure read
        {32'h4000_3000,1'b1,1'b0,2'd0,1'b1,1'b1,2'd1}, // R6 secure passes to mask
        {32'h4000_3004,1'b0,1'b0,2'd0,1'b1,1'b0,2'd0}, // R6 secure read ok
        {32'h4000_4000,1'b1,1'b0,2'd1,1'b1,1'b1,2'd3}, // R7 lock
        {32'h4000_4000,1'b1,1'b0,2'd0,1'b0,1'b1,2'd3}, // R9 lock over mask
        {32'h4000_4004,1'b1,1'b0,2'd1,1'b0,1'b0,2'd0}, // R7 other offset
        {32'h4000_4000,1'b0,1'b0,2'd1,1'b0,1'b0,2'd0}, // R7 read
        {32'h4000_5000,1'b1,1'b0,2'd1,1'b0,1'b0,2'd0}, // R7 no lock enable
        {32'h4000_6000,1'b1,1'b0,2'd0,1'b0,1'b1,2'd2}, // R9 secure over lock
        {32'h3FFF_F000,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0}, // R8 below first
        {32'h4000_8000,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0}, // R8 past last
        {32'h4000_7000,1'b1,1'b0,2'd3,1'b0,1'b0,2'd0}, // R13 core3
        {32'h4000_7004,1'b1,1'b1,2'd3,1'b0,1'b0,2'd0}, // R13 sys3
        {32'h4000_7004,1'b1,1'b0,2'd2,1'b0,1'b1,2'd1}, // R13 core2 still blocked
        {32'h4000_6004,1'b0,1'b0,2'd0,1'b1,1'b0,2'd0}  // R6 secure read ok
    };

    task automatic run_txn(input logic [31:0] a, input logic wr, input logic sys,
                           input logic [1:0] id, input logic sec,
                           input logic exp_err, input logic [1:0] exp_cause);
        int lat;
        bit seen_dn;
        logic [31:0] dn_a;
        @(negedge clk);
        up_addr = a; up_write = wr; up_req_sys = sys; up_req_idx = id;
        up_secure = sec; up_wdata = ~a; up_valid = 1;
        @(posedge clk);
        @(negedge clk);
        up_valid = 0;
        check(!up_ready, "R11 ready low after accept", 32'(up_ready), 0);
        lat = 1; seen_dn = 0; dn_a = '0;
        while (!up_rvalid && lat < 20) begin
            if (dn_valid) begin seen_dn = 1; dn_a = dn_addr; end
            @(negedge clk);
            lat++;
        end
        check(up_err == exp_err, "R2/R6/R7 error flag", 32'(up_err), 32'(exp_err));
        check(lat == (exp_err ? 2 : 3), "R11 response latency", 32'(lat), exp_err ? 2 : 3);
        check(seen_dn == !exp_err, "R8 forwarding", 32'(seen_dn), 32'(!exp_err));
        if (seen_dn) check(dn_a == a, "R8 forwarded address", dn_a, a);
        check(viol_valid == exp_err, "R10 violation strobe", 32'(viol_valid), 32'(exp_err));
        if (exp_err) begin
            check(viol_cause == exp_cause, "R9 cause code", 32'(viol_cause), 32'(exp_cause));
            check(viol_addr == a, "R10 violation address", viol_addr, a);
            check(viol_id == {sys, id}, "R10 violation id", 32'(viol_id), 32'({sys, id}));
            check(up_rdata == 0, "R12 error data zero", up_rdata, 0);
        end else if (!wr) begin
            check(up_rdata == (a ^ 32'h5A5A_0000), "R12 read data", up_rdata, a ^ 32'h5A5A_0000);
        end
        @(posedge clk);
    endtask

    initial begin
        cfg_prot = '0;
        cfg_prot[1*32 +: 32] = 32'h0000_0002;
        cfg_prot[2*32 +: 32] = 32'h0005_0000;
        cfg_prot[3*32 +: 32] = 32'h0007_0007;
        cfg_prot[4*32 +: 32] = 32'h0000_0001;
        cfg_prot[6*32 +: 32] = 32'h0000_0001;
        cfg_prot[7*32 +: 32] = 32'hFFFF_FFFF;
        cfg_slv_secure = 8'b0100_1000;
        cfg_lock_en    = 8'b0101_0000;
        cfg_glock      = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(up_ready == 1, "R1 ready in reset", 32'(up_ready), 1);
        check(!up_rvalid && !dn_valid && !viol_valid, "R1 outputs idle",
              32'({up_rvalid, dn_valid, viol_valid}), 0);
        rst_n = 1;
        @(negedge clk);
        check(up_ready == 1, "R1 ready after reset", 32'(up_ready), 1);

        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][39:8], VEC[i][7], VEC[i][6], VEC[i][5:4], VEC[i][3],
                    VEC[i][2], VEC[i][1:0]);
        end

        // R7 global lock lowered: lock no longer applies, mask still does (R9)
        cfg_glock = 1'b0;
        run_txn(32'h4000_4000, 1, 0, 2'd1, 0, 0, 2'd0);
        run_txn(32'h4000_4000, 1, 0, 2'd0, 0, 1, 2'd1);
        cfg_glock = 1'b1;

        // R11 stalls on both sides
        dn_ready = 0;
        @(negedge clk);
        up_addr = 32'h4000_0100; up_write = 0; up_req_sys = 0; up_req_idx = 0;
        up_secure = 0; up_valid = 1;
        @(posedge clk);
        @(negedge clk);
        up_valid = 0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(dn_valid && !up_rvalid && !up_ready, "R11 hold while peripheral stalls",
                  32'({dn_valid, up_rvalid, up_ready}), 32'b100);
            @(negedge clk);
        end
        up_rready = 0;
        dn_ready = 1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(up_rvalid && !up_err, "R11 response held", 32'({up_rvalid, up_err}), 32'b10);
            @(negedge clk);
        end
        check(up_rdata == (32'h4000_0100 ^ 32'h5A5A_0000), "R12 stalled read data",
              up_rdata, 32'h4000_0100 ^ 32'h5A5A_0000);
        up_rready = 1;
        @(negedge clk);
        check(up_ready && !up_rvalid, "R11 back to idle", 32'({up_ready, up_rvalid}), 32'b10);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule